// File: doc/BRIEF.md
# Cache Maintenance Command Front-End

This block is the register front-end of an outer cache's maintenance queue. Software writes a command word that names an operation, a scope and a target. It then writes the operands that this command needs: a start address and a byte size for range commands, and a way mask for way-based commands. The block holds the command in a staging state until every required operand has arrived. It then checks the operands and offers the command to the operation engine over a valid/ready handshake. While the engine works, the block reports busy. When the engine signals done, the block raises a completion flag if the command asked for one.

Two flag registers tell software how a command went. The set-status register reports whether a command was rejected: either it was refused because the queue was occupied, or it had a bad operand or a reserved field. The queue-status register reports completion (write one to clear), staging and busy. A separate immediate-code register posts a sync or prefetch-buffer-flush request on its own valid/ready channel.

Back-pressure: `cmd_valid` rises only when a command is complete and checked. It stays high, with every `cmd_*` field unchanged, until a cycle in which `cmd_ready` is high. Nothing new is offered until `eng_done` returns. `prim_valid` follows the same rule with `prim_ready`.

Top module: `cmaint_front`

## Requirements
- R1: The command word is read as follows: operation code in bits 2:0 (0 invalidate, 1 clean, 2 flush, 3 prefetch to cache, 4 prefetch to buffer, 5 touch, 6 touch zero, 7 touch dirty), the extra flag in bit 14, the notify request in bit 15, the scope in bits 18:17 (0 range, 1 whole cache, 2 ways) and the target in bits 22:21 (0 LRU data, 1 LRU instruction, 2 explicit ways). These fields appear on `cmd_op`, `cmd_cw`, `cmd_notify`, `cmd_scope` and `cmd_target` while the command is offered.
- R2: Register offsets are: 0 command, 1 start address, 2 size, 3 way mask, 4 set-status, 5 queue-status, 6 immediate code. A range-scope command is offered only after both the address and the size have been written since the command. A command with ways scope or ways target is offered only after the way mask has been written. `cmd_valid` rises two clock edges after the write of the last required operand.
- R3: A command that needs no operand (whole scope with an LRU target) is offered two edges after the command write.
- R4: A command write while a command is staged, offered or running sets FE (set-status bit 1) and is dropped.
- R5: OE (set-status bit 0) is set, and the command is discarded, when a range command has a size of 0 or a size above 0x3FFF80, or when the scope or target field holds the reserved value 3. A size of exactly 0x3FFF80 is accepted.
- R6: A command write that is accepted into staging clears both FE and OE.
- R7: `cmd_valid` with its fields holds until `cmd_ready`. After the handshake, QST (queue-status bit 0) reads 1 until `eng_done`. EST (bit 1) reads 1 while a command is staged or offered.
- R8: On `eng_done` for a running command with the notify bit set, EF (queue-status bit 2) is set, so queue-status reads exactly 0x4. Without the notify bit, EF stays 0.
- R9: Writing 1 to queue-status bit 2 clears EF. Writing 0 there leaves EF unchanged. A set in the same cycle wins over the clear.
- R10: Writes to the address, size or way registers are ignored while a command is offered or running. Their readback is unchanged.
- R11: Writing 0x8 or 0x9 to the immediate register raises `prim_valid` with that code until `prim_ready`. Any other value, or a write while one is pending, is ignored. The register reads back the pending bit in bit 31 and the last code in bits 3:0.
- R12: After reset, every register reads 0 and `cmd_valid` and `prim_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 3 | Operation code |
| cmd_scope | output | 2 | Scope field |
| cmd_target | output | 2 | Target field |
| cmd_notify | output | 1 | Completion notify request |
| cmd_cw | output | 1 | Extra command flag |
| cmd_addr | output | 32 | Range start address |
| cmd_size | output | 32 | Range size in bytes |
| cmd_ways | output | 32 | Way mask |
| eng_done | input | 1 | Engine finished the running command |
| prim_valid | output | 1 | Immediate request pending |
| prim_ready | input | 1 | Immediate request taken |
| prim_code | output | 4 | Immediate code (0x8 sync, 0x9 prefetch-buffer flush) |

## Verification
The hardest case to reach is a collision between the flag logic and the sequencer. This includes a queue-status clear that lands in the same cycle as `eng_done`, and a command write that arrives while the engine is still running. The bench produces these by driving the engine handshake itself. It holds `cmd_ready` low to keep a command offered, it keeps `eng_done` back to keep a command running, and it places the status write and `eng_done` on one edge. A behavioural model follows every edge and compares the offered command and the immediate channel on each clock.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int DW   = 32;
  localparam int NREG = 7;

  localparam int OFS_CMD  = 0;
  localparam int OFS_ADDR = 1;
  localparam int OFS_SIZE = 2;
  localparam int OFS_WAYS = 3;
  localparam int OFS_SET  = 4;
  localparam int OFS_QST  = 5;
  localparam int OFS_PRIM = 6;

  localparam int CW_BIT  = 14;
  localparam int CE_BIT  = 15;
  localparam int SCP_LSB = 17;
  localparam int TGT_LSB = 21;
  localparam int EF_BIT  = 2;

  localparam logic [1:0] SCP_RANGE = 2'd0;
  localparam logic [1:0] SCP_WAYS  = 2'd2;
  localparam logic [1:0] TGT_WAYS  = 2'd2;
  localparam logic [1:0] FLD_RSVD  = 2'd3;

  localparam logic [3:0] PRIM_SYNC  = 4'h8;
  localparam logic [3:0] PRIM_PFBUF = 4'h9;

  typedef enum logic [1:0] {ST_IDLE, ST_STAGE, ST_OFFER, ST_RUN} seq_st_t;

  typedef struct packed {
    logic [1:0] target;
    logic [1:0] scope;
    logic       ce;
    logic       cw;
    logic [2:0] op;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [DW-1:0] w);
    cmd_t c;
    c.op     = w[2:0];
    c.cw     = w[CW_BIT];
    c.ce     = w[CE_BIT];
    c.scope  = w[SCP_LSB +: 2];
    c.target = w[TGT_LSB +: 2];
    return c;
  endfunction
endpackage

// File: rtl/cmf_decode.sv
module cmf_decode #(
  parameter int ADDR_W = 3,
  parameter int NREG   = 7
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wstb
);
  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_stb
      assign wstb[i] = wr && (addr == ADDR_W'(i));
    end
  endgenerate
endmodule

// File: rtl/cmf_seq.sv
module cmf_seq
  import cmf_pkg::*;
#(
  parameter logic [DW-1:0] MAX_SIZE = 32'h003F_FF80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic          wr_addr,
  input  logic          wr_size,
  input  logic          wr_ways,
  input  logic          wr_qst,
  input  logic [DW-1:0] wdata,
  input  logic          cmd_ready,
  input  logic          eng_done,
  output logic          cmd_valid,
  output cmd_t          cmd_f,
  output logic [DW-1:0] cmd_word_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] size_q,
  output logic [DW-1:0] ways_q,
  output logic          fe,
  output logic          oe,
  output logic          ef,
  output logic          est,
  output logic          qst
);
  seq_st_t st;
  logic    got_a, got_s, got_w;
  cmd_t    inc;
  logic    need_rng, need_ways, complete, size_bad, fields_bad, opr_open, ef_set;

  always_comb begin
    cmd_f      = unpack_cmd(cmd_word_q);
    inc        = unpack_cmd(wdata);
    need_rng   = (cmd_f.scope == SCP_RANGE);
    need_ways  = (cmd_f.scope == SCP_WAYS) || (cmd_f.target == TGT_WAYS);
    complete   = (!need_rng || (got_a && got_s)) && (!need_ways || got_w);
    size_bad   = need_rng && ((size_q == '0) || (size_q > MAX_SIZE));
    fields_bad = (inc.scope == FLD_RSVD) || (inc.target == FLD_RSVD);
    opr_open   = (st == ST_IDLE) || (st == ST_STAGE);
    ef_set     = (st == ST_RUN) && eng_done && cmd_f.ce;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cmd_word_q <= '0;
      addr_q     <= '0;
      size_q     <= '0;
      ways_q     <= '0;
      got_a      <= 1'b0;
      got_s      <= 1'b0;
      got_w      <= 1'b0;
      fe         <= 1'b0;
      oe         <= 1'b0;
      ef         <= 1'b0;
    end else begin
      if (opr_open && wr_addr) begin
        addr_q <= wdata;
        if (st == ST_STAGE) got_a <= 1'b1;
      end
      if (opr_open && wr_size) begin
        size_q <= wdata;
        if (st == ST_STAGE) got_s <= 1'b1;
      end
      if (opr_open && wr_ways) begin
        ways_q <= wdata;
        if (st == ST_STAGE) got_w <= 1'b1;
      end

      if (ef_set) ef <= 1'b1;
      else if (wr_qst && wdata[EF_BIT]) ef <= 1'b0;

      if (wr_cmd && st != ST_IDLE) fe <= 1'b1;

      unique case (st)
        ST_IDLE: begin
          if (wr_cmd) begin
            if (fields_bad) begin
              oe <= 1'b1;
              fe <= 1'b0;
            end else begin
              cmd_word_q <= wdata;
              fe    <= 1'b0;
              oe    <= 1'b0;
              got_a <= 1'b0;
              got_s <= 1'b0;
              got_w <= 1'b0;
              st    <= ST_STAGE;
            end
          end
        end
        ST_STAGE: begin
          if (complete) begin
            if (size_bad) begin
              oe <= 1'b1;
              st <= ST_IDLE;
            end else begin
              st <= ST_OFFER;
            end
          end
        end
        ST_OFFER: if (cmd_ready) st <= ST_RUN;
        ST_RUN:   if (eng_done)  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == ST_OFFER);
  assign est       = (st == ST_STAGE) || (st == ST_OFFER);
  assign qst       = (st == ST_RUN);
endmodule

// File: rtl/cmf_prim.sv
module cmf_prim
  import cmf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_prim,
  input  logic [DW-1:0] wdata,
  input  logic          prim_ready,
  output logic          prim_valid,
  output logic [3:0]    prim_code
);
  logic legal;

  assign legal = (wdata[DW-1:4] == '0) &&
                 ((wdata[3:0] == PRIM_SYNC) || (wdata[3:0] == PRIM_PFBUF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_valid <= 1'b0;
      prim_code  <= '0;
    end else if (prim_valid && prim_ready) begin
      prim_valid <= 1'b0;
    end else if (wr_prim && legal && !prim_valid) begin
      prim_valid <= 1'b1;
      prim_code  <= wdata[3:0];
    end
  end
endmodule

// File: rtl/cmaint_front.sv
module cmaint_front
  import cmf_pkg::*;
#(
  parameter int              ADDR_W   = 3,
  parameter logic [DW-1:0]   MAX_SIZE = 32'h003F_FF80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [1:0]        cmd_scope,
  output logic [1:0]        cmd_target,
  output logic              cmd_notify,
  output logic              cmd_cw,
  output logic [31:0]       cmd_addr,
  output logic [31:0]       cmd_size,
  output logic [31:0]       cmd_ways,
  input  logic              eng_done,
  output logic              prim_valid,
  input  logic              prim_ready,
  output logic [3:0]        prim_code
);
  logic [NREG-1:0] wstb;
  cmd_t            cf;
  logic [DW-1:0]   cmd_word_q, addr_q, size_q, ways_q;
  logic            fe_w, oe_w, ef_w, est_w, qst_w;

  cmf_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .wr(reg_wr), .addr(reg_addr), .wstb(wstb)
  );

  cmf_seq #(.MAX_SIZE(MAX_SIZE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd(wstb[OFS_CMD]), .wr_addr(wstb[OFS_ADDR]), .wr_size(wstb[OFS_SIZE]),
    .wr_ways(wstb[OFS_WAYS]), .wr_qst(wstb[OFS_QST]), .wdata(reg_wdata),
    .cmd_ready(cmd_ready), .eng_done(eng_done),
    .cmd_valid(cmd_valid), .cmd_f(cf), .cmd_word_q(cmd_word_q),
    .addr_q(addr_q), .size_q(size_q), .ways_q(ways_q),
    .fe(fe_w), .oe(oe_w), .ef(ef_w), .est(est_w), .qst(qst_w)
  );

  cmf_prim u_prim (
    .clk(clk), .rst_n(rst_n), .wr_prim(wstb[OFS_PRIM]), .wdata(reg_wdata),
    .prim_ready(prim_ready), .prim_valid(prim_valid), .prim_code(prim_code)
  );

  assign cmd_op     = cf.op;
  assign cmd_scope  = cf.scope;
  assign cmd_target = cf.target;
  assign cmd_notify = cf.ce;
  assign cmd_cw     = cf.cw;
  assign cmd_addr   = addr_q;
  assign cmd_size   = size_q;
  assign cmd_ways   = ways_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_CMD):  reg_rdata = cmd_word_q;
      ADDR_W'(OFS_ADDR): reg_rdata = addr_q;
      ADDR_W'(OFS_SIZE): reg_rdata = size_q;
      ADDR_W'(OFS_WAYS): reg_rdata = ways_q;
      ADDR_W'(OFS_SET):  reg_rdata = {30'b0, fe_w, oe_w};
      ADDR_W'(OFS_QST):  reg_rdata = {29'b0, ef_w, est_w, qst_w};
      ADDR_W'(OFS_PRIM): reg_rdata = {prim_valid, 27'b0, prim_code};
      default:           reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmaint_front_chk.sv
module cmaint_front_chk #(
  parameter logic [31:0] MAX_SIZE = 32'h003F_FF80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [2:0]  cmd_op,
  input logic [1:0]  cmd_scope,
  input logic [31:0] cmd_size,
  input logic [31:0] cmd_addr,
  input logic        eng_done,
  input logic        qst,
  input logic        ef,
  input logic        prim_valid,
  input logic        prim_ready,
  input logic [3:0]  prim_code
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_size));

  assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> qst && !cmd_valid);

  assert_no_offer_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qst |-> !cmd_valid);

  assert_size_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_scope == 2'd0 |-> cmd_size != 32'd0 && cmd_size <= MAX_SIZE);

  assert_ef_from_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ef) |-> $past(eng_done) && $past(qst));

  assert_prim_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> prim_code == 4'h8 || prim_code == 4'h9);

  assert_prim_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && !prim_ready |=> prim_valid && $stable(prim_code));
endmodule

bind cmaint_front cmaint_front_chk #(.MAX_SIZE(MAX_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_scope(cmd_scope), .cmd_size(cmd_size), .cmd_addr(cmd_addr),
  .eng_done(eng_done), .qst(qst_w), .ef(ef_w), .prim_valid(prim_valid),
  .prim_ready(prim_ready), .prim_code(prim_code)
);

// File: tb/cmaint_front_bench.sv
module cmaint_front_bench;
  localparam logic [31:0] MAXSZ = 32'h003F_FF80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid, cmd_notify, cmd_cw;
  logic        cmd_ready = 1'b0;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_scope, cmd_target;
  logic [31:0] cmd_addr, cmd_size, cmd_ways;
  logic        eng_done = 1'b0;
  logic        prim_valid;
  logic        prim_ready = 1'b0;
  logic [3:0]  prim_code;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cmaint_front u_cmaint_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_scope(cmd_scope),
    .cmd_target(cmd_target), .cmd_notify(cmd_notify), .cmd_cw(cmd_cw),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_ways(cmd_ways),
    .eng_done(eng_done), .prim_valid(prim_valid), .prim_ready(prim_ready),
    .prim_code(prim_code)
  );

  // behavioural reference: 0 idle, 1 waiting operands, 2 offered, 3 running
  int          m_st;
  logic [31:0] m_cmd, m_addr, m_size, m_ways;
  bit          m_ga, m_gs, m_gw, m_fe, m_oe, m_ef, m_pp;
  logic [3:0]  m_pc;
  int          t_st, t_sc, t_tg;
  bit          t_nr, t_nw, t_ok;
  logic [31:0] t_sz;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cmd = 0; m_addr = 0; m_size = 0; m_ways = 0;
      m_ga = 0; m_gs = 0; m_gw = 0; m_fe = 0; m_oe = 0; m_ef = 0;
      m_pp = 0; m_pc = 0;
    end else begin
      t_st = m_st; t_sz = m_size;
      t_sc = int'(m_cmd[18:17]); t_tg = int'(m_cmd[22:21]);
      t_nr = (t_sc == 0); t_nw = (t_sc == 2) || (t_tg == 2);
      t_ok = (!t_nr || (m_ga && m_gs)) && (!t_nw || m_gw);
      if (t_st == 3 && eng_done && m_cmd[15]) m_ef = 1;
      else if (reg_wr && reg_addr == 5 && reg_wdata[2]) m_ef = 0;
      if (t_st <= 1 && reg_wr) begin
        if (reg_addr == 1) begin m_addr = reg_wdata; if (t_st == 1) m_ga = 1; end
        if (reg_addr == 2) begin m_size = reg_wdata; if (t_st == 1) m_gs = 1; end
        if (reg_addr == 3) begin m_ways = reg_wdata; if (t_st == 1) m_gw = 1; end
      end
      if (reg_wr && reg_addr == 0) begin
        if (t_st != 0) m_fe = 1;
        else if (reg_wdata[18:17] == 3 || reg_wdata[22:21] == 3) begin m_oe = 1; m_fe = 0; end
        else begin
          m_cmd = reg_wdata; m_fe = 0; m_oe = 0; m_ga = 0; m_gs = 0; m_gw = 0; m_st = 1;
        end
      end
      if (t_st == 1 && t_ok) begin
        if (t_nr && (t_sz == 0 || t_sz > MAXSZ)) begin m_oe = 1; m_st = 0; end
        else m_st = 2;
      end
      if (t_st == 2 && cmd_ready) m_st = 3;
      if (t_st == 3 && eng_done) m_st = 0;
      if (m_pp && prim_ready) m_pp = 0;
      else if (reg_wr && reg_addr == 6 && !m_pp && (reg_wdata == 32'h8 || reg_wdata == 32'h9)) begin
        m_pp = 1; m_pc = reg_wdata[3:0];
      end
    end
  end

  // per-clock comparison of the offered command (R1, R2, R7) and immediate channel (R11)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      total++;
      if (cmd_valid !== (m_st == 2)) begin
        bad++; $display("FAIL R2/R7 cmd_valid actual=%0b expected=%0b", cmd_valid, m_st == 2);
      end else if (m_st == 2 &&
          ({cmd_op, cmd_cw, cmd_notify, cmd_scope, cmd_target} !==
           {m_cmd[2:0], m_cmd[14], m_cmd[15], m_cmd[18:17], m_cmd[22:21]} ||
           cmd_addr !== m_addr || cmd_size !== m_size || cmd_ways !== m_ways)) begin
        bad++; $display("FAIL R1 fields actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
          {cmd_target, cmd_scope, cmd_notify, cmd_cw, cmd_op}, cmd_addr, cmd_size, cmd_ways,
          {m_cmd[22:21], m_cmd[18:17], m_cmd[15], m_cmd[14], m_cmd[2:0]}, m_addr, m_size, m_ways);
      end
      total++;
      if (prim_valid !== m_pp || (m_pp && prim_code !== m_pc)) begin
        bad++; $display("FAIL R11 prim actual=%0b/%h expected=%0b/%h", prim_valid, prim_code, m_pp, m_pc);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++; $display("FAIL %s reg%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic take();
    cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    rd_chk(3'd5, 32'h0, "R12");
    rd_chk(3'd4, 32'h0, "R12");
    rd_chk(3'd6, 32'h0, "R12");
    rd_chk(3'd0, 32'h0, "R12");

    // R3 whole-cache flush with notify
    wr(3'd0, (32'd1 << 17) | (32'd1 << 15) | 32'd2);
    tick(3);
    rd_chk(3'd5, 32'h2, "R3");
    tick(2);                                // held without ready (R7)
    take();
    rd_chk(3'd5, 32'h1, "R7");
    wr(3'd1, 32'h1234);                     // ignored while running
    rd_chk(3'd1, 32'h0, "R10");
    wr(3'd0, 32'd2);                        // refused while running
    rd_chk(3'd4, 32'h2, "R4");
    done();
    rd_chk(3'd5, 32'h4, "R8");
    wr(3'd5, 32'h0);
    rd_chk(3'd5, 32'h4, "R9");
    wr(3'd5, 32'h4);
    rd_chk(3'd5, 32'h0, "R9");

    // R2 range invalidate with extra flag, operands in turn
    wr(3'd0, (32'd1 << 15) | (32'd1 << 14));
    rd_chk(3'd4, 32'h0, "R6");
    wr(3'd1, 32'h8000);
    tick(3);
    rd_chk(3'd5, 32'h2, "R2");
    wr(3'd2, 32'h100);
    tick(2);
    take();
    wr(3'd2, 32'h200);
    rd_chk(3'd2, 32'h100, "R10");
    done();
    rd_chk(3'd5, 32'h4, "R8");
    wr(3'd5, 32'h4);

    // R5 size boundaries
    wr(3'd0, 32'd1);
    wr(3'd1, 32'h4000);
    wr(3'd2, 32'h0);
    tick(2);
    rd_chk(3'd4, 32'h1, "R5");
    rd_chk(3'd5, 32'h0, "R5");
    wr(3'd0, 32'd1);
    wr(3'd1, 32'h4000);
    wr(3'd2, 32'h003F_FF81);
    tick(2);
    rd_chk(3'd4, 32'h1, "R5");
    wr(3'd0, 32'd1);
    rd_chk(3'd4, 32'h0, "R6");
    wr(3'd2, 32'h003F_FF80);
    wr(3'd1, 32'h4000);
    tick(2);
    rd_chk(3'd4, 32'h0, "R5");
    take();
    done();
    rd_chk(3'd5, 32'h0, "R8");              // no notify, no EF
    wr(3'd0, 32'd3 << 17);                  // reserved scope
    tick(1);
    rd_chk(3'd4, 32'h1, "R5");
    rd_chk(3'd5, 32'h0, "R5");
    wr(3'd0, (32'd3 << 21) | (32'd1 << 17));// reserved target
    rd_chk(3'd4, 32'h1, "R5");

    // R2 ways scope needs the way mask only
    wr(3'd0, (32'd2 << 17) | (32'd1 << 15));
    wr(3'd1, 32'hAAAA);
    wr(3'd2, 32'h80);
    tick(2);
    rd_chk(3'd5, 32'h2, "R2");
    wr(3'd3, 32'hF);
    tick(2);
    take();
    // R9 set wins over a clear in the same cycle
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h4; eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_done = 1'b0;
    rd_chk(3'd5, 32'h4, "R9");
    wr(3'd5, 32'h4);

    // R2 whole scope with ways target (prefetch) needs the way mask
    wr(3'd0, (32'd2 << 21) | (32'd1 << 17) | 32'd3);
    tick(3);
    rd_chk(3'd5, 32'h2, "R2");
    wr(3'd3, 32'h3);
    tick(2);
    take();
    done();
    rd_chk(3'd0, (32'd2 << 21) | (32'd1 << 17) | 32'd3, "R1");

    // R11 immediate codes
    wr(3'd6, 32'h8);
    rd_chk(3'd6, 32'h8000_0008, "R11");
    wr(3'd6, 32'h9);
    rd_chk(3'd6, 32'h8000_0008, "R11");
    prim_ready = 1'b1; @(negedge clk); prim_ready = 1'b0;
    rd_chk(3'd6, 32'h0000_0008, "R11");
    wr(3'd6, 32'h5);
    rd_chk(3'd6, 32'h0000_0008, "R11");
    wr(3'd6, 32'h9);
    tick(2);
    rd_chk(3'd6, 32'h8000_0009, "R11");
    prim_ready = 1'b1; @(negedge clk); prim_ready = 1'b0;

    tick(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule